// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous host and an asynchronous static RAM. The host side is a valid/ready port that carries one word per request: an address, a direction, and write data for writes. The RAM side has a 21-bit address, an 8-bit bidirectional data bus, and four strobes. There are two chip enables of opposite polarity, an active-low write strobe and an active-low output enable. For each accepted request the controller runs one complete, properly timed bus cycle. When a read finishes it returns the sampled byte with a one-cycle valid pulse. When a write finishes it acknowledges with the same pulse.

The RAM timing limits are parameters in picoseconds, together with the clock period. The cycle counts are derived from them by ceiling division, with a floor of one cycle. At the defaults (20 ns clock, 55 ns speed grade) a read keeps the output enable low for 3 cycles. A write holds the write strobe low for 3 cycles and drives the data bus for the last 2 of them plus one hold cycle.

The sequencer states are IDLE, RD_ACC, WR_SETUP, WR_STRB, WR_DATA, WR_HOLD and TURN. Their transitions are:
- IDLE to RD_ACC, or IDLE to WR_SETUP, when a request is accepted.
- RD_ACC to TURN when the read window count expires.
- WR_SETUP to WR_STRB, then WR_STRB to WR_DATA, after one cycle each.
- WR_DATA to WR_HOLD when the data window count expires.
- WR_HOLD to TURN after one cycle.
- TURN to IDLE when the turnaround count expires.

Top module: `sram_async_ctl`

## Requirements
- R1: During and after reset, and whenever no access is in progress, the RAM is deselected (`ram_ce_n`=1, `ram_ce`=0), `ram_we_n`=1, `ram_oe_n`=1, `req_ready`=1 and `rsp_valid`=0.
- R2: A request is taken at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the access and its turnaround are over. Request inputs presented while `req_ready` is 0 have no effect on the bus.
- R3: A read selects the RAM with `ram_we_n`=1 and `ram_oe_n`=0 for exactly the read window (3 cycles at defaults), starting in the cycle after acceptance.
- R4: Read data is captured at the last clock edge of the read window and appears on `rsp_rdata` with `rsp_valid`=1 for exactly one cycle, the first turnaround cycle.
- R5: A write keeps the RAM selected with `ram_oe_n`=1 throughout. It runs one setup cycle with `ram_we_n`=1, then `ram_we_n`=0 for the strobe length (3 cycles at defaults), then one hold cycle with `ram_we_n`=1.
- R6: The controller drives `ram_dq` with the request's write data only from the second write-strobe cycle through the hold cycle, and never while `ram_oe_n` is 0.
- R7: A write completion is acknowledged by `rsp_valid`=1 for exactly one cycle, the first turnaround cycle.
- R8: `ram_addr` equals the accepted address while the RAM is selected, and changes only while `ram_we_n` is 1.
- R9: Every access ends with at least one deselected turnaround cycle, in which `req_ready` is 0, before the controller returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte from the last read |
| ram_addr | output | 21 | RAM address lines |
| ram_dq | inout | 8 | RAM bidirectional data bus |
| ram_ce_n | output | 1 | Active-low chip enable |
| ram_ce | output | 1 | Active-high chip enable |
| ram_we_n | output | 1 | Active-low write strobe |
| ram_oe_n | output | 1 | Active-low output enable |

## Verification
The hardest case to reach from the ports is a host that keeps `req_valid` high while the controller is busy. In that case new address, direction and data values arrive mid-cycle, and they must neither disturb the running cycle nor start a new one before the turnaround. The bench reaches this by chaining requests: the next request's fields are placed on the port in the cycle right after acceptance and left there until `req_ready` returns. The bench also mixes in long randomized runs of chained and gapped reads and writes.

A behavioural RAM model samples the bus at the rising write strobe and serves reads. Data that went to the wrong address or outside the drive window therefore shows up later as a wrong read byte.

// File: rtl/sram_async_pkg.sv
package sram_async_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_WR_SETUP,
        ST_WR_STRB,
        ST_WR_DATA,
        ST_WR_HOLD,
        ST_TURN
    } seq_state_t;

    // Whole clock cycles covering a time span, never less than one.
    function automatic int unsigned ceil_cyc(input int unsigned span_ps,
                                             input int unsigned clk_ps);
        int unsigned q;
        q = (span_ps + clk_ps - 1) / clk_ps;
        return (q == 0) ? 1 : q;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
// Down-counter that times the length of a sequencer state.
module sram_wait_cnt #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
// Access sequencer: state register, next-state logic, registered strobes.
module sram_seq_fsm
    import sram_async_pkg::*;
#(
    parameter int CNT_W    = 2,
    parameter int RD_CYC   = 3,
    parameter int WD_CYC   = 2,
    parameter int TURN_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             cnt_last,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             take,
    output logic             sample,
    output logic             ready_o,
    output logic             sel_o,
    output logic             we_n_o,
    output logic             oe_n_o,
    output logic             drv_o,
    output logic             rsp_valid_o
);
    seq_state_t state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:     if (req_valid) state_nxt = req_write ? ST_WR_SETUP : ST_RD_ACC;
            ST_RD_ACC:   if (cnt_last)  state_nxt = ST_TURN;
            ST_WR_SETUP:                state_nxt = ST_WR_STRB;
            ST_WR_STRB:                 state_nxt = ST_WR_DATA;
            ST_WR_DATA:  if (cnt_last)  state_nxt = ST_WR_HOLD;
            ST_WR_HOLD:                 state_nxt = ST_TURN;
            ST_TURN:     if (cnt_last)  state_nxt = ST_IDLE;
            default:                    state_nxt = ST_IDLE;
        endcase
    end

    // State duration counter is reloaded on every state entry.
    always_comb begin
        cnt_load = (state_nxt != state);
        unique case (state_nxt)
            ST_RD_ACC:  cnt_val = CNT_W'(RD_CYC - 1);
            ST_WR_DATA: cnt_val = CNT_W'(WD_CYC - 1);
            ST_TURN:    cnt_val = CNT_W'(TURN_CYC - 1);
            default:    cnt_val = '0;
        endcase
    end

    assign take   = (state == ST_IDLE) && req_valid;
    assign sample = (state == ST_RD_ACC) && cnt_last;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Registered outputs, decoded from the state being entered.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_o     <= 1'b1;
            sel_o       <= 1'b0;
            we_n_o      <= 1'b1;
            oe_n_o      <= 1'b1;
            drv_o       <= 1'b0;
            rsp_valid_o <= 1'b0;
        end else begin
            ready_o     <= (state_nxt == ST_IDLE);
            sel_o       <= (state_nxt != ST_IDLE) && (state_nxt != ST_TURN);
            we_n_o      <= !((state_nxt == ST_WR_STRB) || (state_nxt == ST_WR_DATA));
            oe_n_o      <= (state_nxt != ST_RD_ACC);
            drv_o       <= (state_nxt == ST_WR_DATA) || (state_nxt == ST_WR_HOLD);
            rsp_valid_o <= (state_nxt == ST_TURN) && (state != ST_TURN);
        end
    end
endmodule

// File: rtl/sram_bus_path.sv
// Address and write-data holding registers, tri-state driver, read capture.
module sram_bus_path #(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              sample,
    input  logic              drv,
    output logic [ADDR_W-1:0] ram_addr,
    inout  wire  [DATA_W-1:0] ram_dq,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ram_addr <= '0;
            wdata_q  <= '0;
        end else if (take) begin
            ram_addr <= req_addr;
            wdata_q  <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rsp_rdata <= '0;
        else if (sample) rsp_rdata <= ram_dq;
    end

    assign ram_dq = drv ? wdata_q : {DATA_W{1'bz}};
endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
    import sram_async_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int DATA_W    = 8,
    parameter int CLK_PS    = 20000,
    parameter int T_RC_PS   = 55000,
    parameter int T_AA_PS   = 55000,
    parameter int T_OE_PS   = 30000,
    parameter int T_WC_PS   = 55000,
    parameter int T_WP_PS   = 45000,
    parameter int T_DW_PS   = 25000,
    parameter int T_WHZ_PS  = 20000,
    parameter int T_CHZ_PS  = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    inout  wire  [DATA_W-1:0] ram_dq,
    output logic              ram_ce_n,
    output logic              ram_ce,
    output logic              ram_we_n,
    output logic              ram_oe_n
);
    localparam int unsigned RD_CYC = max2(max2(ceil_cyc(T_RC_PS, CLK_PS),
                                               ceil_cyc(T_AA_PS, CLK_PS)),
                                          ceil_cyc(T_OE_PS, CLK_PS));
    localparam int unsigned WC_CYC  = ceil_cyc(T_WC_PS, CLK_PS);
    localparam int unsigned WC_LOW  = (WC_CYC > 2) ? WC_CYC - 2 : 1;
    // Strobe must cover pulse width, setup after the bus turn-on cycle,
    // turn-off of the RAM drivers plus setup, and the full write cycle.
    localparam int unsigned WE_LOW  = max2(max2(ceil_cyc(T_WP_PS, CLK_PS),
                                                ceil_cyc(T_DW_PS, CLK_PS) + 1),
                                           max2(ceil_cyc(T_WHZ_PS + T_DW_PS, CLK_PS),
                                                WC_LOW));
    localparam int unsigned WD_CYC   = WE_LOW - 1;
    localparam int unsigned TURN_CYC = ceil_cyc(T_CHZ_PS, CLK_PS);
    localparam int unsigned MAX_CYC  = max2(max2(RD_CYC, WD_CYC), TURN_CYC);
    localparam int          CNT_W    = $clog2(MAX_CYC + 1);

    logic             sel, we_n, oe_n, drv;
    logic             take, sample;
    logic             cnt_load, cnt_last;
    logic [CNT_W-1:0] cnt_val;

    sram_seq_fsm #(
        .CNT_W   (CNT_W),
        .RD_CYC  (RD_CYC),
        .WD_CYC  (WD_CYC),
        .TURN_CYC(TURN_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .cnt_last   (cnt_last),
        .cnt_load   (cnt_load),
        .cnt_val    (cnt_val),
        .take       (take),
        .sample     (sample),
        .ready_o    (req_ready),
        .sel_o      (sel),
        .we_n_o     (we_n),
        .oe_n_o     (oe_n),
        .drv_o      (drv),
        .rsp_valid_o(rsp_valid)
    );

    sram_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_val),
        .last    (cnt_last)
    );

    sram_bus_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .sample   (sample),
        .drv      (drv),
        .ram_addr (ram_addr),
        .ram_dq   (ram_dq),
        .rsp_rdata(rsp_rdata)
    );

    assign ram_ce_n = ~sel;
    assign ram_ce   = sel;
    assign ram_we_n = we_n;
    assign ram_oe_n = oe_n;
endmodule

// File: rtl/sram_async_ctl_chk.sv
module sram_async_ctl_chk #(
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_ce_n,
    input logic              ram_ce,
    input logic              ram_we_n,
    input logic              ram_oe_n,
    input logic              drv
);
    logic selected;
    assign selected = !ram_ce_n && ram_ce;

    // R8: address moves only with the write strobe inactive on both sides of the edge
    a_r8_addr_safe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ram_addr) |-> ram_we_n && $past(ram_we_n));

    // R3: output enable only during a selected read
    a_r3_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |-> selected && ram_we_n);

    // R5: write strobe only while selected with outputs disabled
    a_r5_we_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> selected && ram_oe_n);

    // R6: controller drives the bus only while selected and the RAM outputs are off
    a_r6_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
        drv |-> selected && ram_oe_n);

    // R6: no drive in the cycle the write strobe falls
    a_r6_no_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_we_n) |-> !drv);

    // R2: ready only while the bus is fully idle
    a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !selected && !drv && ram_we_n && ram_oe_n);

    // R7: completion pulse lasts one cycle and occurs deselected
    a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !selected ##1 !rsp_valid);
endmodule

bind sram_async_ctl sram_async_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .ram_addr (ram_addr),
    .ram_ce_n (ram_ce_n),
    .ram_ce   (ram_ce),
    .ram_we_n (ram_we_n),
    .ram_oe_n (ram_oe_n),
    .drv      (drv)
);

// File: tb/sim_sram_async_ctl.sv
`timescale 1ns/1ps
module sim_sram_async_ctl;
    // Expected cycle counts at default timing, 20 ns clock.
    localparam int B_RD   = (55000 + 19999) / 20000;          // 3
    localparam int B_WLOW = (45000 + 19999) / 20000;          // 3
    localparam int B_WD   = B_WLOW - 1;                       // 2
    localparam int B_TURN = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [20:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [20:0] ram_addr;
    wire  [7:0]  ram_dq;
    logic        ram_ce_n, ram_ce, ram_we_n, ram_oe_n;

    always #10 clk = ~clk;

    sram_async_ctl u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ram_addr(ram_addr), .ram_dq(ram_dq),
        .ram_ce_n(ram_ce_n), .ram_ce(ram_ce), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n)
    );

    function automatic logic [7:0] dflt(input logic [20:0] a);
        return a[7:0] ^ a[20:13] ^ 8'hC3;
    endfunction

    // Behavioural RAM, indexed by low address byte with a full-address tag.
    logic [7:0]   mem [0:255];
    logic [20:0]  tag [0:255];
    logic [255:0] vld = '0;
    wire          ram_sel = !ram_ce_n && ram_ce;
    wire          ram_drv = ram_sel && ram_we_n && !ram_oe_n;
    wire  [7:0]   idx = ram_addr[7:0];
    wire  [7:0]   ram_rd = (vld[idx] && tag[idx] == ram_addr) ? mem[idx] : dflt(ram_addr);
    assign ram_dq = ram_drv ? ram_rd : 8'bz;

    always @(posedge ram_we_n) begin
        if (ram_sel) begin
            mem[idx] <= ram_dq;
            tag[idx] <= ram_addr;
            vld[idx] <= 1'b1;
        end
    end

    int addr_viol = 0;
    always @(ram_addr) if (ram_sel && !ram_we_n) addr_viol++;

    // Reference model: expected pin state per cycle.
    typedef struct {
        int          kind;   // 0 idle, 1 read, 2 write, 3 turnaround
        bit          rd;
        bit          sel, we_n, oe_n, rdy, rsp, dq_chk, rd_chk;
        logic [20:0] addr;
        logic [7:0]  val;
    } exp_t;

    exp_t        q[$];
    logic [7:0]  shadow [int];
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic string tag_of(input exp_t e);
        case (e.kind)
            1: return "R3";
            2: return "R5";
            3: return "R9";
            default: return "R1";
        endcase
    endfunction

    task automatic compare();
        exp_t e;
        if (q.size() > 0) e = q.pop_front();
        else begin
            e = '{kind:0, rd:0, sel:0, we_n:1, oe_n:1, rdy:1, rsp:0,
                  dq_chk:0, rd_chk:0, addr:'0, val:'0};
        end
        chk(ram_ce_n == !e.sel && ram_ce == e.sel, tag_of(e), "enables",
            {ram_ce_n, ram_ce}, {!e.sel, e.sel});
        chk(ram_we_n == e.we_n, tag_of(e), "we_n", ram_we_n, e.we_n);
        chk(ram_oe_n == e.oe_n, (e.kind == 2) ? "R6" : tag_of(e), "oe_n", ram_oe_n, e.oe_n);
        chk(req_ready == e.rdy, (e.kind == 0) ? "R1" : "R2", "ready", req_ready, e.rdy);
        chk(rsp_valid == e.rsp, (e.kind == 3) ? (e.rd ? "R4" : "R7") : "R1",
            "rsp_valid", rsp_valid, e.rsp);
        if (e.sel) chk(ram_addr == e.addr, "R8", "ram_addr", ram_addr, e.addr);
        if (e.dq_chk) chk(ram_dq === e.val, "R6", "ram_dq", ram_dq, e.val);
        if (e.rd_chk) chk(rsp_rdata == e.val, "R4", "rsp_rdata", rsp_rdata, e.val);
    endtask

    task automatic step();
        @(negedge clk);
        compare();
    endtask

    task automatic push_seq(input bit wr, input logic [20:0] a, input logic [7:0] d);
        exp_t e;
        if (!wr) begin
            logic [7:0] rv;
            rv = shadow.exists(int'(a)) ? shadow[int'(a)] : dflt(a);
            for (int i = 0; i < B_RD; i++)
                q.push_back('{kind:1, rd:1, sel:1, we_n:1, oe_n:0, rdy:0, rsp:0,
                              dq_chk:0, rd_chk:0, addr:a, val:'0});
            for (int i = 0; i < B_TURN; i++)
                q.push_back('{kind:3, rd:1, sel:0, we_n:1, oe_n:1, rdy:0, rsp:(i == 0),
                              dq_chk:0, rd_chk:(i == 0), addr:a, val:rv});
        end else begin
            q.push_back('{kind:2, rd:0, sel:1, we_n:1, oe_n:1, rdy:0, rsp:0,
                          dq_chk:0, rd_chk:0, addr:a, val:d});
            q.push_back('{kind:2, rd:0, sel:1, we_n:0, oe_n:1, rdy:0, rsp:0,
                          dq_chk:0, rd_chk:0, addr:a, val:d});
            for (int i = 0; i < B_WD; i++)
                q.push_back('{kind:2, rd:0, sel:1, we_n:0, oe_n:1, rdy:0, rsp:0,
                              dq_chk:1, rd_chk:0, addr:a, val:d});
            q.push_back('{kind:2, rd:0, sel:1, we_n:1, oe_n:1, rdy:0, rsp:0,
                          dq_chk:1, rd_chk:0, addr:a, val:d});
            for (int i = 0; i < B_TURN; i++)
                q.push_back('{kind:3, rd:0, sel:0, we_n:1, oe_n:1, rdy:0, rsp:(i == 0),
                              dq_chk:0, rd_chk:0, addr:a, val:d});
            shadow[int'(a)] = d;
        end
    endtask

    // Present a request; when chain is set, valid stays high after acceptance (R2).
    task automatic op(input bit wr, input logic [20:0] a, input logic [7:0] d, input bit chain);
        req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
        while (!req_ready) step();
        push_seq(wr, a, d);
        step();
        if (!chain) req_valid = 1'b0;
    endtask

    function automatic logic [20:0] rnd_addr(input logic [7:0] lb);
        return {lb[4:0] ^ 5'h13, ~lb, lb};
    endfunction

    initial begin
        logic [31:0] seed;
        // R1: reset state
        for (int i = 0; i < 4; i++) step();
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) step();

        // R5 R6 R7: single writes with idle gaps, extreme addresses
        op(1, 21'h000000, 8'hA5, 0); repeat (2) step();
        op(1, 21'h1FFFFF, 8'h3C, 0); repeat (3) step();
        op(1, 21'h0ABCDE, 8'h77, 0); step();
        op(1, 21'h155555, 8'h81, 0); repeat (2) step();

        // R3 R4: reads back, plus a never-written location
        op(0, 21'h1FFFFF, 8'h00, 0); step();
        op(0, 21'h000000, 8'h00, 0); step();
        op(0, 21'h012345, 8'h00, 0); repeat (2) step();
        op(0, 21'h0ABCDE, 8'h00, 0); step();

        // R2 R8 R9: chained requests, fields change while busy
        op(1, 21'h155555, 8'h42, 1);
        op(0, 21'h155555, 8'h99, 1);
        op(1, 21'h0ABCDE, 8'hE1, 1);
        op(0, 21'h0ABCDE, 8'h00, 1);
        op(0, 21'h000000, 8'h00, 0);
        repeat (3) step();

        // Randomized mix of chained and gapped accesses
        seed = 32'h1234_5678;
        for (int n = 0; n < 300; n++) begin
            logic [7:0] lb;
            seed = seed * 32'd1664525 + 32'd1013904223;
            lb = 8'h80 | (seed[13:8] & 8'h3F);
            op(seed[16], rnd_addr(lb), seed[31:24], seed[20]);
            if (!seed[20]) repeat (seed[26:25]) step();
        end
        req_valid = 1'b0;
        repeat (12) step();

        chk(addr_viol == 0, "R8", "addr changes with strobe low", addr_viol, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R2 actual=hung expected=complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule